// File: doc/BRIEF.md
# Hamming Check-Code Syndrome Corrector

This block compares the 3-byte check code read back with a 256-byte flash data chunk against the 3-byte code recomputed from that chunk. The syndrome is the bytewise XOR of the two codes. The block classifies the syndrome into one of four results: no error, a single flipped data bit, a single flipped bit in the stored code, or an uncorrectable error. For a data error it also reports the byte address inside the chunk and a one-hot bit mask. The caller XORs the mask into the addressed byte of its buffer.

The check runs as a single registered stage. A request presented with `in_valid` appears on the result outputs one clock later. Result fields keep their value between requests.

Alongside the check, a small combinational path packs a 24-bit raw parity word from the stream accumulator into the byte order used for storage.

Byte k of any 24-bit code port sits in bits [8k+7:8k].

Top module: `ecc_hm_corrector`

## Requirements
- R1: After reset, `out_valid` and `fix_strobe` are 0. A request with `in_valid` high at a rising edge raises `out_valid` for exactly the following cycle, carrying that request's result.
- R2: A zero syndrome gives status 2'b00 (clean). `fix_strobe` stays 0, and `fix_addr` and `fix_mask` are 0.
- R3: A syndrome counts as a data error (status 2'b01, `fix_strobe` high) when two conditions hold. In syndrome bytes 0 and 1, bits 2k+1 and 2k differ for every k in 0..3. In syndrome byte 2, the bit pairs (7,6), (5,4) and (3,2) differ. Bits 1 and 0 of byte 2 are not checked.
- R4: For a data error, `fix_addr` is, MSB first, bits 7,5,3,1 of syndrome byte 0 followed by bits 7,5,3,1 of syndrome byte 1.
- R5: For a data error, the bit index is, MSB first, bits 7,5,3 of syndrome byte 2. `fix_mask` is 1 shifted left by that index.
- R6: A syndrome with exactly one bit set gives status 2'b10 (code error). `fix_strobe` is 0, and `fix_addr` and `fix_mask` are 0.
- R7: Any other non-zero syndrome gives status 2'b11 (uncorrectable). `fix_strobe` is 0, and `fix_addr` and `fix_mask` are 0.
- R8: `packed_code` is formed from w = ~`acc_word` | 24'h030000. Its byte 0 is w[15:8], its byte 1 is w[7:0] and its byte 2 is w[23:16].
- R9: A cycle without `in_valid` drops `out_valid` and `fix_strobe` to 0 and leaves `status`, `fix_addr` and `fix_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compare request |
| stored_code | input | 24 | Check code read from flash |
| calc_code | input | 24 | Check code recomputed from the read data |
| acc_word | input | 24 | Raw parity accumulator value |
| packed_code | output | 24 | Accumulator value in storage byte order |
| out_valid | output | 1 | Result valid |
| status | output | 2 | 00 clean, 01 data fixed, 10 code fixed, 11 uncorrectable |
| fix_strobe | output | 1 | Apply correction to the buffer |
| fix_addr | output | 8 | Byte address of the faulty data byte |
| fix_mask | output | 8 | One-hot mask to XOR into that byte |

## Verification
Random code pairs almost never give a correctable data syndrome, because all eleven bit pairs must disagree. The stimulus therefore builds such syndromes directly from a chosen address and bit index, with random values in the two unchecked low bits of byte 2, and XORs each onto a random stored code. Single-bit syndromes at every one of the 24 positions are applied in the same way. The stimulus also covers near misses, where a data-error syndrome has one pair bit flipped, to confirm that they fall into the uncorrectable class.

// File: rtl/ecc_hm_pkg.sv
package ecc_hm_pkg;
  localparam int BYTE_W     = 8;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = BYTE_W * CODE_BYTES;
  localparam int ADDR_W     = 8;
  localparam int IDX_W      = 3;
  localparam int MASK_W     = 1 << IDX_W;
  localparam logic [BYTE_W-1:0] PAIR_FULL  = 8'h55;
  localparam logic [BYTE_W-1:0] PAIR_SHORT = 8'h54;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_DATA_FIX = 2'b01,
    ST_CODE_FIX = 2'b10,
    ST_UNCORR   = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc_hm_pack.sv
module ecc_hm_pack
  import ecc_hm_pkg::*;
#(
  parameter logic [CODE_W-1:0] FORCE_ONES = 24'h030000
) (
  input  logic [CODE_W-1:0] raw,
  output logic [CODE_W-1:0] packed_out
);
  logic [CODE_W-1:0] inv_w;

  always_comb begin
    inv_w      = ~raw | FORCE_ONES;
    // storage order: byte1, byte0, byte2
    packed_out = {inv_w[23:16], inv_w[7:0], inv_w[15:8]};
  end
endmodule

// File: rtl/ecc_hm_classify.sv
module ecc_hm_classify
  import ecc_hm_pkg::*;
(
  input  logic [CODE_W-1:0] syn,
  output ecc_status_e       cls,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  logic [CODE_BYTES-1:0] pair_ok;
  logic [BYTE_W-1:0]     s0, s1, s2;

  assign s0 = syn[7:0];
  assign s1 = syn[15:8];
  assign s2 = syn[23:16];

  for (genvar b = 0; b < CODE_BYTES; b++) begin : g_pair
    localparam logic [BYTE_W-1:0] PM = (b == CODE_BYTES-1) ? PAIR_SHORT : PAIR_FULL;
    logic [BYTE_W-1:0] sb;
    assign sb         = syn[b*BYTE_W +: BYTE_W];
    assign pair_ok[b] = ((sb ^ (sb >> 1)) & PM) == PM;
  end

  for (genvar i = 0; i < 4; i++) begin : g_addr
    assign addr[ADDR_W-1-i] = s0[BYTE_W-1-2*i];
    assign addr[3-i]        = s1[BYTE_W-1-2*i];
  end

  for (genvar i = 0; i < IDX_W; i++) begin : g_idx
    assign idx[IDX_W-1-i] = s2[BYTE_W-1-2*i];
  end

  always_comb begin
    if (syn == '0)                 cls = ST_CLEAN;
    else if (&pair_ok)             cls = ST_DATA_FIX;
    else if ($countones(syn) == 1) cls = ST_CODE_FIX;
    else                           cls = ST_UNCORR;
  end
endmodule

// File: rtl/ecc_hm_corrector.sv
module ecc_hm_corrector
  import ecc_hm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [23:0]       stored_code,
  input  logic [23:0]       calc_code,
  input  logic [23:0]       acc_word,
  output logic [23:0]       packed_code,
  output logic              out_valid,
  output logic [1:0]        status,
  output logic              fix_strobe,
  output logic [7:0]        fix_addr,
  output logic [7:0]        fix_mask
);
  logic [CODE_W-1:0] syn;
  ecc_status_e       cls;
  logic [ADDR_W-1:0] cls_addr;
  logic [IDX_W-1:0]  cls_idx;

  ecc_status_e       status_d, status_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [MASK_W-1:0] mask_d, mask_q;
  logic              valid_q;

  assign syn = calc_code ^ stored_code;

  ecc_hm_classify u_classify (
    .syn  (syn),
    .cls  (cls),
    .addr (cls_addr),
    .idx  (cls_idx)
  );

  ecc_hm_pack u_pack (
    .raw        (acc_word),
    .packed_out (packed_code)
  );

  always_comb begin
    status_d = cls;
    addr_d   = '0;
    mask_d   = '0;
    if (cls == ST_DATA_FIX) begin
      addr_d = cls_addr;
      mask_d = MASK_W'(1) << cls_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      status_q <= ST_CLEAN;
      addr_q   <= '0;
      mask_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        status_q <= status_d;
        addr_q   <= addr_d;
        mask_q   <= mask_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign status     = status_q;
  assign fix_addr   = addr_q;
  assign fix_mask   = mask_q;
  assign fix_strobe = valid_q && (status_q == ST_DATA_FIX);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_clean_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stored_code == calc_code) |=> (status == 2'b00 && !fix_strobe));
  a_r3_strobe_only_data: assert property (@(posedge clk) disable iff (!rst_n)
    fix_strobe |-> (status == 2'b01 && out_valid));
  a_r5_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    fix_strobe |-> $onehot(fix_mask));
  a_r6_code_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(stored_code ^ calc_code) == 1)
      |=> (status == 2'b10 && fix_mask == 8'h00 && !fix_strobe));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(status) && $stable(fix_addr) && $stable(fix_mask)));
endmodule

// File: tb/test_ecc_hm_corrector.sv
module test_ecc_hm_corrector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] stored_code, calc_code, acc_word;
  logic [23:0] packed_code;
  logic        out_valid, fix_strobe;
  logic [1:0]  status;
  logic [7:0]  fix_addr, fix_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_hm_corrector i_ecc_hm_corrector (
    .clk, .rst_n, .in_valid, .stored_code, .calc_code, .acc_word,
    .packed_code, .out_valid, .status, .fix_strobe, .fix_addr, .fix_mask
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result, computed bit by bit from R2..R7
  function automatic void model(input logic [23:0] s, output logic [1:0] st,
                                output logic [7:0] ad, output logic [7:0] mk);
    bit ok = 1'b1;
    int ones = 0;
    int bi = 0;
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 4; k++)
        if (!(b == 2 && k == 0))
          if (s[b*8+2*k+1] == s[b*8+2*k]) ok = 1'b0;
    for (int n = 0; n < 24; n++) ones += int'(s[n]);
    ad = 8'h00; mk = 8'h00;
    if (s == 24'h0) st = 2'b00;
    else if (ok) begin
      st = 2'b01;
      for (int k = 0; k < 4; k++) begin
        ad[7-k] = s[7-2*k];
        ad[3-k] = s[15-2*k];
      end
      for (int k = 0; k < 3; k++) bi = bi * 2 + int'(s[23-2*k]);
      mk = 8'h01 << bi;
    end
    else if (ones == 1) st = 2'b10;
    else st = 2'b11;
  endfunction

  function automatic logic [23:0] data_syn(input logic [7:0] ad, input logic [2:0] ix,
                                           input logic [1:0] low);
    logic [23:0] s = '0;
    for (int k = 0; k < 4; k++) begin
      s[7-2*k]  = ad[7-k];  s[6-2*k]  = ~ad[7-k];
      s[15-2*k] = ad[3-k];  s[14-2*k] = ~ad[3-k];
    end
    for (int k = 0; k < 3; k++) begin
      s[23-2*k] = ix[2-k]; s[22-2*k] = ~ix[2-k];
    end
    s[17:16] = low;
    return s;
  endfunction

  task automatic apply(input logic [23:0] st_c, input logic [23:0] syn, input string tag);
    logic [1:0] es; logic [7:0] ea, em;
    model(syn, es, ea, em);
    @(negedge clk);
    in_valid = 1'b1; stored_code = st_c; calc_code = st_c ^ syn;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 out_valid"}, 32'(out_valid), 32'd1);
    chk({tag, " status"}, 32'(status), 32'(es));
    chk({tag, " R4 fix_addr"}, 32'(fix_addr), 32'(ea));
    chk({tag, " R5 fix_mask"}, 32'(fix_mask), 32'(em));
    chk({tag, " R3 fix_strobe"}, 32'(fix_strobe), 32'(es == 2'b01));
  endtask

  task automatic check_pack(input logic [23:0] a);
    logic [23:0] w;
    w = ~a | 24'h030000;
    acc_word = a;
    #1;
    chk("R8 packed_code", 32'(packed_code), 32'({w[23:16], w[7:0], w[15:8]}));
  endtask

  initial begin
    void'($urandom(32'h5EED_0ECC));
    rst_n = 1'b0; in_valid = 1'b0;
    stored_code = '0; calc_code = '0; acc_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset fix_strobe", 32'(fix_strobe), 32'd0);
    rst_n = 1'b1;

    apply(24'hA5C3_11, 24'h0, "R2 clean");
    apply(24'h123456, data_syn(8'h00, 3'd0, 2'b00), "R3 addr0 bit0");
    apply(24'h123456, data_syn(8'hFF, 3'd7, 2'b11), "R3 addr255 bit7");
    apply(24'h0F0F0F, data_syn(8'hA5, 3'd4, 2'b10), "R4 addrA5");
    apply(24'hFFFFFF, data_syn(8'h5A, 3'd3, 2'b01) ^ 24'h000004, "R7 near miss");
    for (int n = 0; n < 24; n++)
      apply(24'($urandom), 24'h1 << n, "R6 single bit");
    apply(24'h000000, 24'h000003, "R7 two bits");

    // R9: idle cycle keeps fields, drops valid
    apply(24'h777777, data_syn(8'h3C, 3'd6, 2'b00), "R9 setup");
    @(negedge clk);
    stored_code = 24'h000000; calc_code = 24'hFFFFFF;
    @(negedge clk);
    chk("R9 out_valid low", 32'(out_valid), 32'd0);
    chk("R9 fix_strobe low", 32'(fix_strobe), 32'd0);
    chk("R9 status held", 32'(status), 32'd1);
    chk("R9 fix_addr held", 32'(fix_addr), 32'h3C);
    chk("R9 fix_mask held", 32'(fix_mask), 32'h40);

    for (int n = 0; n < 200; n++) begin
      case ($urandom % 4)
        0: apply(24'($urandom), data_syn(8'($urandom), 3'($urandom), 2'($urandom)), "R3 rand data");
        1: apply(24'($urandom), 24'h1 << ($urandom % 24), "R6 rand code");
        2: apply(24'($urandom), 24'h0, "R2 rand clean");
        default: apply(24'($urandom), 24'($urandom), "R7 rand any");
      endcase
    end

    check_pack(24'h000000);
    check_pack(24'hFFFFFF);
    check_pack(24'h123456);
    for (int n = 0; n < 20; n++) check_pack(24'($urandom));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule